// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel

This block is one channel of a timer array. It watches a shared free-running 16-bit counter and, depending on an 8-bit mode register, either timestamps edges on an external pin, raises a flag when the counter reaches a programmed value, toggles its pin on matches, generates a square wave, or produces a pulse-width-modulated waveform. The PWM period is 8, 9, 10, 11 or 16 bits. The 8-to-11-bit length comes from a configuration field shared by all channels.

The channel uses a single 16-bit capture/compare register for every mode. In PWM modes a second auto-reload register holds the next duty value, so a duty change takes effect only at a period boundary. An output-only polarity bit inverts the driven pin. A sticky flag, a period-wrap flag and an interrupt request report events to software.

Top module: `ccp_channel`

## Requirements
- R1: A synchronous active-high reset clears the mode, capture/compare, auto-reload and polarity registers, the pin state and both flags. After reset, pin_out, flag, irq and cap_val are all 0.
- R2: Capture is selected when mode[3:1]=000 and mode[5:4]≠00. The value 10 captures on a rising pin edge, 01 on a falling edge and 11 on either edge. The pin passes through a two-stage synchroniser, so the counter value present at the third rising clock edge after the pin changes is latched into cap_val. The flag is set at that same edge.
- R3: Software timer mode is mode[3:1]=100. The flag is set when the counter advances to a value equal to the 16-bit compare register. A counter that has not changed since the previous cycle causes no match. The pin state does not change.
- R4: High-speed output mode is mode[3:1]=110. Each 16-bit match, under the same advance rule as R3, toggles the pin state and sets the flag.
- R5: Frequency output mode is mode[3:1]=011. When the counter advances to a value whose low byte equals the compare low byte, the pin state toggles and the flag is set. The compare low byte then becomes itself plus the compare high byte, modulo 256.
- R6: mode[6] enables the comparator. When it is 0, no match event occurs in the timer, high-speed, frequency and PWM modes, and every PWM mode drives pin state 0.
- R7: PWM mode is mode[2:1]=01. With mode[7]=1 the period is 16 bits. Otherwise it is 8 + pwm_len[1:0] bits, or 11 bits when pwm_len[2]=1. At each clock edge the pin state becomes 1 when the counter's low N bits are greater than or equal to the compare value (low N bits), and 0 otherwise.
- R8: In PWM mode the compare register is loaded from the auto-reload register at each period wrap, and that same cycle already compares against the new value. For 16 bits, a wrap is cnt_ovf. For N<16, a wrap is a cycle whose low N bits are zero while the previous cycle's low N bits were not.
- R9: A compare write (cmp_we) goes to the auto-reload register when reg_sel=1 and the channel is in a PWM mode. Otherwise it goes to the capture/compare register, and a same-cycle capture, advance or reload yields to it.
- R10: In PWM mode with mode[3]=1, the flag is set when the counter advances to a value whose low N bits equal the compare value.
- R11: The flag stays set until a flag_clr strobe. A wrap flag is set on each N-bit wrap of the shared length, independent of mode, and flag_clr also clears it. A set in the same cycle as a clear wins. irq = (flag and mode[0]) or (wrap flag and ovf_ie).
- R12: pin_out is the pin state XOR the polarity bit. A pol_we write changes pin_out at the next clock edge regardless of the counter phase. Capture sees pin_in without inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 16 | Shared counter value |
| cnt_ovf | input | 1 | Strobe: counter wrapped from FFFF to 0 this cycle |
| pin_in | input | 1 | External channel pin input |
| mode_we | input | 1 | Mode register write strobe |
| mode_wd | input | 8 | Mode register write data |
| cmp_we | input | 1 | Compare/reload write strobe |
| cmp_wd | input | 16 | Compare/reload write data |
| reg_sel | input | 1 | Shared: route compare writes to auto-reload in PWM modes |
| pwm_len | input | 3 | Shared PWM length code |
| ovf_ie | input | 1 | Shared: wrap interrupt enable |
| pol_we | input | 1 | Polarity write strobe |
| pol_wd | input | 1 | Polarity write data |
| flag_clr | input | 1 | Clears both flags |
| pin_out | output | 1 | Channel pin drive |
| flag | output | 1 | Match/capture flag |
| irq | output | 1 | Interrupt request |
| cap_val | output | 16 | Capture/compare register readback |

## Verification
Every registered result depends on the inputs sampled at one rising edge. Pin state, flag, compare updates and cap_val therefore change at the first edge that sees the triggering counter value. The two exceptions are capture, which lands on the third edge after the pin moves, and polarity, which changes one edge after its write. The bench drives inputs 1 ns after each rising edge and updates a behavioural model at that edge. It compares all outputs 1 ns after every edge, so each result is checked in exactly the cycle it is due.

// File: rtl/ccp_channel.sv
module ccp_channel (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cnt_in,
  input  logic        cnt_ovf,
  input  logic        pin_in,
  input  logic        mode_we,
  input  logic [7:0]  mode_wd,
  input  logic        cmp_we,
  input  logic [15:0] cmp_wd,
  input  logic        reg_sel,
  input  logic [2:0]  pwm_len,
  input  logic        ovf_ie,
  input  logic        pol_we,
  input  logic        pol_wd,
  input  logic        flag_clr,
  output logic        pin_out,
  output logic        flag,
  output logic        irq,
  output logic [15:0] cap_val
);
  logic [7:0]  mode_q;
  logic [15:0] ccr_q, arr_q, cnt_q;
  logic [2:0]  sync_q;
  logic        pol_q, state_q, flag_q, cyc_q;

  wire [2:0] sel    = mode_q[3:1];
  wire is_cap       = (sel == 3'b000) && (mode_q[5:4] != 2'b00);
  wire is_tmr       = (sel == 3'b100);
  wire is_hso       = (sel == 3'b110);
  wire is_frq       = (sel == 3'b011);
  wire is_pwm       = (mode_q[2:1] == 2'b01);
  wire cmp_on       = mode_q[6];
  wire advance      = (cnt_in != cnt_q);

  wire [1:0]  shamt = pwm_len[2] ? 2'd3 : pwm_len[1:0];
  wire [15:0] nmask = (16'h0100 << shamt) - 16'd1;
  wire [15:0] pmask = mode_q[7] ? 16'hFFFF : nmask;
  wire nwrap        = ((cnt_in & nmask) == 16'd0) && ((cnt_q & nmask) != 16'd0);
  wire pwrap        = mode_q[7] ? cnt_ovf : nwrap;
  wire [15:0] cuse  = pwrap ? arr_q : ccr_q;
  wire [15:0] low   = cnt_in & pmask;
  wire [15:0] cmpm  = cuse & pmask;
  wire pwm_lvl      = cmp_on && (low >= cmpm);

  wire hit16 = cmp_on && advance && (cnt_in == ccr_q);
  wire hit8  = cmp_on && advance && (cnt_in[7:0] == ccr_q[7:0]);
  wire hitp  = cmp_on && mode_q[3] && advance && (low == cmpm);

  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire cap_hit = is_cap && ((mode_q[5] && rise) || (mode_q[4] && fall));

  wire set_flag = cap_hit || ((is_tmr || is_hso) && hit16) ||
                  (is_frq && hit8) || (is_pwm && hitp);
  wire wr_arr   = cmp_we && reg_sel && is_pwm;
  wire wr_ccr   = cmp_we && !(reg_sel && is_pwm);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      ccr_q   <= '0;
      arr_q   <= '0;
      cnt_q   <= '0;
      sync_q  <= '0;
      pol_q   <= 1'b0;
      state_q <= 1'b0;
      flag_q  <= 1'b0;
      cyc_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_in;
      sync_q <= {sync_q[1:0], pin_in};
      flag_q <= set_flag | (flag_q & ~flag_clr);
      cyc_q  <= nwrap | (cyc_q & ~flag_clr);
      if (mode_we) mode_q <= mode_wd;
      if (pol_we)  pol_q  <= pol_wd;
      if (wr_arr)  arr_q  <= cmp_wd;
      if (wr_ccr)                 ccr_q      <= cmp_wd;
      else if (cap_hit)           ccr_q      <= cnt_in;
      else if (is_frq && hit8)    ccr_q[7:0] <= ccr_q[7:0] + ccr_q[15:8];
      else if (is_pwm && pwrap)   ccr_q      <= arr_q;
      if (is_pwm)                                     state_q <= pwm_lvl;
      else if ((is_hso && hit16) || (is_frq && hit8)) state_q <= ~state_q;
    end
  end

  assign pin_out = state_q ^ pol_q;
  assign flag    = flag_q;
  assign irq     = (flag_q & mode_q[0]) | (cyc_q & ovf_ie);
  assign cap_val = ccr_q;

  assert_cap_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (cap_hit && !cmp_we) |=> (cap_val == $past(cnt_in)) && flag);
  assert_timer_pin_R3: assert property (@(posedge clk) disable iff (rst)
    (is_tmr || is_cap) |=> $stable(state_q));
  assert_out_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    ((is_hso || is_frq) && !cmp_on) |=> $stable(state_q));
  assert_pwm_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && !cmp_on) |=> !state_q);
  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && pwrap && !cmp_we) |=> (cap_val == $past(arr_q)));
  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
endmodule

// File: tb/tb_ccp_channel.sv
`timescale 1ns/1ps
module tb_ccp_channel;
  logic clk = 0, rst = 1;
  logic [15:0] cnt_in = 0; logic cnt_ovf = 0; logic pin_in = 0;
  logic mode_we = 0; logic [7:0] mode_wd = 0;
  logic cmp_we = 0; logic [15:0] cmp_wd = 0; logic reg_sel = 0;
  logic [2:0] pwm_len = 0; logic ovf_ie = 0;
  logic pol_we = 0, pol_wd = 0, flag_clr = 0;
  logic pin_out, flag, irq; logic [15:0] cap_val;

  ccp_channel dut (.clk(clk), .rst(rst), .cnt_in(cnt_in), .cnt_ovf(cnt_ovf), .pin_in(pin_in),
    .mode_we(mode_we), .mode_wd(mode_wd), .cmp_we(cmp_we), .cmp_wd(cmp_wd), .reg_sel(reg_sel),
    .pwm_len(pwm_len), .ovf_ie(ovf_ie), .pol_we(pol_we), .pol_wd(pol_wd), .flag_clr(flag_clr),
    .pin_out(pin_out), .flag(flag), .irq(irq), .cap_val(cap_val));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0; bit done = 0; bit run = 1; string req = "R1";

  // behavioural reference model
  logic [7:0] m_m; logic [15:0] m_ccr, m_arr, m_cq; logic m_pol, m_st, m_fl, m_cy;
  logic [2:0] m_sy;
  int n, per; logic [15:0] nm, pm, cu; bit adv, nw, pw, cap, tmr, hso, frq, pwm, h16, h8, hp, ev;

  always @(posedge clk) begin
    if (rst) begin
      m_m = 0; m_ccr = 0; m_arr = 0; m_cq = 0; m_pol = 0; m_st = 0; m_fl = 0; m_cy = 0; m_sy = 0;
    end else begin
      n   = pwm_len[2] ? 11 : 8 + int'(pwm_len[1:0]);
      nm  = 16'((32'd1 << n) - 1);
      per = m_m[7] ? 16 : n;
      pm  = 16'((32'd1 << per) - 1);
      adv = (cnt_in != m_cq);
      nw  = ((cnt_in & nm) == 0) && ((m_cq & nm) != 0);
      pw  = m_m[7] ? cnt_ovf : nw;
      cu  = pw ? m_arr : m_ccr;
      cap = (m_m[3:1] == 0) && (m_m[5:4] != 0);
      tmr = m_m[3:1] == 3'd4; hso = m_m[3:1] == 3'd6; frq = m_m[3:1] == 3'd3;
      pwm = m_m[2:1] == 2'd1;
      h16 = m_m[6] && adv && cnt_in == m_ccr;
      h8  = m_m[6] && adv && cnt_in[7:0] == m_ccr[7:0];
      hp  = m_m[6] && m_m[3] && adv && ((cnt_in & pm) == (cu & pm));
      ev  = cap && ((m_m[5] && m_sy[1] && !m_sy[2]) || (m_m[4] && !m_sy[1] && m_sy[2]));
      m_fl = ev || ((tmr || hso) && h16) || (frq && h8) || (pwm && hp) || (m_fl && !flag_clr);
      m_cy = nw || (m_cy && !flag_clr);
      if (pwm) m_st = m_m[6] && ((cnt_in & pm) >= (cu & pm));
      else if ((hso && h16) || (frq && h8)) m_st = !m_st;
      if (cmp_we && !(reg_sel && pwm)) m_ccr = cmp_wd;
      else if (ev) m_ccr = cnt_in;
      else if (frq && h8) m_ccr[7:0] = m_ccr[7:0] + m_ccr[15:8];
      else if (pwm && pw) m_ccr = m_arr;
      if (cmp_we && reg_sel && pwm) m_arr = cmp_wd;
      if (mode_we) m_m = mode_wd;
      if (pol_we) m_pol = pol_wd;
      m_sy = {m_sy[1:0], pin_in};
      m_cq = cnt_in;
    end
  end

  task automatic tick();
    logic ei;
    @(posedge clk); #1;
    ei = (m_fl && m_m[0]) || (m_cy && ovf_ie);
    checks++;
    if (pin_out !== (m_st ^ m_pol) || flag !== m_fl || irq !== ei || cap_val !== m_ccr) begin
      fails++;
      $display("FAIL %s t=%0t pin=%b/%b flag=%b/%b irq=%b/%b cap=%h/%h (actual/expected)",
               req, $time, pin_out, m_st ^ m_pol, flag, m_fl, irq, ei, cap_val, m_ccr);
    end
    if (run) begin cnt_ovf = (cnt_in == 16'hFFFF); cnt_in = cnt_in + 16'd1; end
    else cnt_ovf = 0;
  endtask

  task automatic go(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask
  task automatic setmode(input logic [7:0] v);
    mode_we = 1; mode_wd = v; tick(); mode_we = 0;
  endtask
  task automatic setcmp(input logic [15:0] v);
    cmp_we = 1; cmp_wd = v; tick(); cmp_we = 0;
  endtask
  task automatic setpol(input logic v);
    pol_we = 1; pol_wd = v; tick(); pol_we = 0;
  endtask
  task automatic clr();
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  initial begin
    req = "R1"; run = 0;
    go(3); rst = 0; go(3);
    run = 1;
    // R2 capture modes
    req = "R2"; setmode(8'h21);
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; go(7); end
    clr(); setmode(8'h11);
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; go(7); end
    setmode(8'h31);
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; go(5); clr(); end
    req = "R12"; setpol(1); pin_in = ~pin_in; go(6); setpol(0);
    // R3 software timer
    req = "R3"; clr(); setcmp(16'h1240); cnt_in = 16'h1230; setmode(8'h49); go(30);
    run = 0; go(3); run = 1; clr(); go(5);
    // R4 high-speed output
    req = "R4"; setmode(8'h4C); setcmp(16'h1270); go(40); cnt_in = 16'h1268; go(20);
    // R5 frequency output
    req = "R5"; clr(); setcmp(16'h0510); setmode(8'h46); go(80);
    setcmp(16'h0100 | {8'h0, cnt_in[7:0] + 8'd3}); go(20);
    // R6 comparator off
    req = "R6"; setmode(8'h0C); setcmp(cnt_in + 16'd5); go(20);
    setmode(8'h06); go(300);
    // R7 / R8 / R9 PWM lengths with reload
    req = "R9"; reg_sel = 0; setmode(8'h42); setcmp(16'h0033); reg_sel = 1; setcmp(16'h0040); go(10);
    for (int l = 0; l < 5; l++) begin
      req = "R7"; pwm_len = 3'(l); go(600 + 512 * l);
      req = "R8"; setcmp(16'h00C0 + 16'(l * 100)); go(700 + 512 * l);
    end
    req = "R8"; setcmp(16'h0000); go(600);
    req = "R9"; setmode(8'h46); setcmp(16'h0211); go(20);
    // R10 PWM match flag and irq
    req = "R10"; pwm_len = 0; setmode(8'h4B); setcmp(16'h0080); clr(); go(300); clr(); go(20);
    // R6 PWM disabled
    req = "R6"; setmode(8'h0A); go(300);
    // PWM16 around the full wrap
    req = "R8"; setmode(8'hC2); setcmp(16'h0020); cnt_in = 16'hFF00; go(400);
    setcmp(16'hFFF0); go(65536 - 16'(cnt_in) + 300);
    // R11 wrap flag and interrupt
    req = "R11"; ovf_ie = 1; pwm_len = 3'd1; setmode(8'h4B); go(1100);
    clr(); go(4); flag_clr = 1; go(600); flag_clr = 0; go(20);
    ovf_ie = 0; go(5);
    // R12 polarity mid-period
    req = "R12"; pwm_len = 0; setpol(1); go(137); setpol(0); go(91); setpol(1); go(30);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog %s actual=running expected=finished", req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule